// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block holds the interrupt status word of a small network controller. Eight sticky event flags occupy the upper byte of a 16-bit word. Each flag is raised either by a one-cycle pulse from a neighbouring engine or by a state transition that the block detects on the command-unit or receive-unit state encodings. Software reads the word through a simple register port and acknowledges events by writing ones to the bits it has handled.

The command-not-active flag follows one of two selectable rules. It can report any departure from the Active state, or only an arrival in Idle. The receive-not-ready flag is raised whenever the receive unit leaves its Ready state. A registered interrupt line is the OR of all eight flags.

Top module: `nic_irq_status`

## Requirements
- R1: After reset the status word reads 0000h and the interrupt line is low.
- R2: A write to word address 0 with byte-lane enable 1 (`bus_be[1]`) clears every flag in bits 15..8 whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A write with `bus_be[1]` low does not change the flags.
- R3: Bits 7..0 always read as zero, and writes to them have no effect.
- R4: A one-cycle pulse sets its flag on the next clock edge: command done with interrupt request sets bit 15, frame received sets bit 14, software request sets bit 10, early receive sets bit 9, and flow-control pause sets bit 8.
- R5: A management-cycle-done pulse sets bit 11 only while `mgmt_irq_en` is 1. With `mgmt_irq_en` at 0 the pulse has no effect.
- R6: Unit states are encoded as Idle=00, Suspended=01, Active/Ready=10 and No-Resources=11. With `cna_mode`=0, bit 13 sets on any clock where the command-unit state changes from 10 to a different value.
- R7: With `cna_mode`=1, bit 13 sets only when the command-unit state changes to 00 from a different value. Leaving 10 for 01 does not set it.
- R8: Bit 12 sets when the receive-unit state changes from 10 to any other value.
- R9: When a set condition and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is registered and equals the OR of bits 15..8 as they stood one clock earlier. It therefore falls one cycle after the last flag is cleared.
- R11: `bus_rdata` combinationally returns the status word when `bus_addr` is 0 and returns zero for any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cmd_done | input | 1 | Command finished with its interrupt request set (pulse) |
| ev_frame_rx | input | 1 | Frame reception finished (pulse) |
| ev_mgmt_done | input | 1 | Management read/write cycle finished (pulse) |
| ev_sw_req | input | 1 | Software interrupt request (pulse) |
| ev_early_rx | input | 1 | Early receive event (pulse) |
| ev_pause | input | 1 | Flow-control pause event (pulse) |
| cu_state | input | 2 | Command-unit state encoding |
| ru_state | input | 2 | Receive-unit state encoding |
| cna_mode | input | 1 | 0: any exit from Active; 1: entry to Idle only |
| mgmt_irq_en | input | 1 | Enables the management-cycle flag |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane write enables |
| bus_wdata | input | 16 | Write data (ones clear flags) |
| bus_rdata | output | 16 | Read data |
| status_word | output | 16 | Current status word |
| irq | output | 1 | Registered combined interrupt |

## Verification
The transition assertions assume that each unit-state input holds one value across a whole clock period. Under that assumption, the value sampled one edge earlier is exactly the state the block compared against. They also ignore the first clock after reset, because at that point the previous state is the reset value rather than a sampled one. The bench changes every input on the falling edge and leaves the state inputs at Idle throughout reset. Each pulse lasts one cycle, so every event is presented to exactly one rising edge.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

  typedef enum logic [1:0] {
    UST_IDLE  = 2'b00,
    UST_SUSP  = 2'b01,
    UST_RUN   = 2'b10,
    UST_NORES = 2'b11
  } unit_st_e;

  // positions inside the 8-bit flag vector (status bit = index + 8)
  localparam int FL_PAUSE = 0;
  localparam int FL_ERX   = 1;
  localparam int FL_SWI   = 2;
  localparam int FL_MGMT  = 3;
  localparam int FL_RNR   = 4;
  localparam int FL_CNA   = 5;
  localparam int FL_FRAME = 6;
  localparam int FL_CMD   = 7;

  function automatic logic left_run(input logic [1:0] prev, input logic [1:0] cur);
    return (prev == UST_RUN) && (cur != UST_RUN);
  endfunction

  function automatic logic entered_idle(input logic [1:0] prev, input logic [1:0] cur);
    return (prev != UST_IDLE) && (cur == UST_IDLE);
  endfunction

  // sticky update: a new set beats a simultaneous clear
  function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/nic_irq_detect.sv
module nic_irq_detect
  import nic_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cu_state,
  input  logic [1:0] ru_state,
  input  logic       cna_mode,
  output logic       cna_evt,
  output logic       rnr_evt
);

  logic [1:0] cu_prev;
  logic [1:0] ru_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cu_prev <= UST_IDLE;
      ru_prev <= UST_IDLE;
    end else begin
      cu_prev <= cu_state;
      ru_prev <= ru_state;
    end
  end

  always_comb begin
    if (cna_mode) cna_evt = entered_idle(cu_prev, cu_state);
    else          cna_evt = left_run(cu_prev, cu_state);
    rnr_evt = left_run(ru_prev, ru_state);
  end

endmodule

// File: rtl/nic_irq_flags.sv
module nic_irq_flags
  import nic_irq_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic [FLAG_W-1:0] clr_vec,
  output logic [FLAG_W-1:0] flags,
  output logic              any_q
);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= w1c_next(flags[i], set_vec[i], clr_vec[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= |flags;
  end

endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
#(
  parameter int STATUS_W = 16,
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_cmd_done,
  input  logic                  ev_frame_rx,
  input  logic                  ev_mgmt_done,
  input  logic                  ev_sw_req,
  input  logic                  ev_early_rx,
  input  logic                  ev_pause,
  input  logic [1:0]            cu_state,
  input  logic [1:0]            ru_state,
  input  logic                  cna_mode,
  input  logic                  mgmt_irq_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [STATUS_W/8-1:0] bus_be,
  input  logic [STATUS_W-1:0]   bus_wdata,
  output logic [STATUS_W-1:0]   bus_rdata,
  output logic [STATUS_W-1:0]   status_word,
  output logic                  irq
);

  localparam int FLAG_W = STATUS_W / 2;
  localparam int LANES  = STATUS_W / 8;
  localparam int HI_LANE = LANES - 1;

  logic              cna_evt;
  logic              rnr_evt;
  logic              reg_hit;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] flags;
  logic              any_q;
  logic              unused_low_lane;

  nic_irq_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .cu_state (cu_state),
    .ru_state (ru_state),
    .cna_mode (cna_mode),
    .cna_evt  (cna_evt),
    .rnr_evt  (rnr_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FL_CMD]   = ev_cmd_done;
    set_vec[FL_FRAME] = ev_frame_rx;
    set_vec[FL_CNA]   = cna_evt;
    set_vec[FL_RNR]   = rnr_evt;
    set_vec[FL_MGMT]  = ev_mgmt_done & mgmt_irq_en;
    set_vec[FL_SWI]   = ev_sw_req;
    set_vec[FL_ERX]   = ev_early_rx;
    set_vec[FL_PAUSE] = ev_pause;
  end

  assign reg_hit = (bus_addr == ADDR_W'(REG_ADDR));
  assign clr_vec = (bus_wr && reg_hit && bus_be[HI_LANE]) ?
                   bus_wdata[STATUS_W-1 -: FLAG_W] : '0;

  // low lane carries reserved bits only
  assign unused_low_lane = ^{bus_be[HI_LANE-1:0], bus_wdata[FLAG_W-1:0]};

  nic_irq_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags),
    .any_q   (any_q)
  );

  assign status_word = {flags, {FLAG_W{1'b0}}};
  assign bus_rdata   = reg_hit ? status_word : '0;
  assign irq         = any_q;

endmodule

// File: rtl/nic_irq_status_chk.sv
module nic_irq_status_chk
  import nic_irq_pkg::*;
#(
  parameter int STATUS_W = 16,
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cna_mode,
  input logic                  mgmt_irq_en,
  input logic [1:0]            cu_state,
  input logic [1:0]            ru_state,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [STATUS_W-1:0]   bus_rdata,
  input logic [STATUS_W-1:0]   status_word,
  input logic                  irq,
  input logic [STATUS_W/2-1:0] set_vec,
  input logic [STATUS_W/2-1:0] clr_vec
);

  localparam int FLAG_W = STATUS_W / 2;

  logic              past_ok;
  logic [FLAG_W-1:0] hi;

  assign hi = status_word[STATUS_W-1 -: FLAG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((hi & $past(set_vec)) == $past(set_vec)));

  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((hi & $past(clr_vec & ~set_vec)) == '0));

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hi & ~$past(set_vec | clr_vec)) == ($past(hi) & ~$past(set_vec | clr_vec))));

  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|hi)));

  assert_mgmt_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mgmt_irq_en && !status_word[11]) |=> !status_word[11]);

  assert_cna_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !cna_mode && cu_state != UST_RUN && $past(cu_state) == UST_RUN)
      |=> status_word[13]);

  assert_cna_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cna_mode && cu_state == UST_IDLE && $past(cu_state) != UST_IDLE)
      |=> status_word[13]);

  assert_rnr_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ru_state != UST_RUN && $past(ru_state) == UST_RUN)
      |=> status_word[12]);

  assert_read_mux_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(REG_ADDR)) ? (bus_rdata == status_word) : (bus_rdata == '0));

endmodule

bind nic_irq_status nic_irq_status_chk #(
  .STATUS_W (STATUS_W),
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR)
) u_chk (.*);

// File: tb/sim_nic_irq_status.sv
`timescale 1ns/1ps
module sim_nic_irq_status;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_cmd_done = 1'b0, ev_frame_rx = 1'b0, ev_mgmt_done = 1'b0;
  logic        ev_sw_req = 1'b0, ev_early_rx = 1'b0, ev_pause = 1'b0;
  logic [1:0]  cu_state = 2'b00, ru_state = 2'b00;
  logic        cna_mode = 1'b0, mgmt_irq_en = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata, status_word;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nic_irq_status u0 (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_be = 2'b00; bus_addr = 4'd0;
  endtask

  task automatic clear_all();
    bus_write(4'd0, 2'b11, 16'hFF00);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 status after reset", status_word, 16'h0000);
    chk("R1 irq after reset", {15'b0, irq}, 16'h0000);
    chk("R11 read after reset", bus_rdata, 16'h0000);
  endtask

  task automatic t_pulses();
    ev_cmd_done = 1'b1; tick(); ev_cmd_done = 1'b0;
    chk("R4 command done", status_word, 16'h8000);
    chk("R10 irq lags set", {15'b0, irq}, 16'h0000);
    tick();
    chk("R10 irq rises", {15'b0, irq}, 16'h0001);
    ev_frame_rx = 1'b1; tick(); ev_frame_rx = 1'b0;
    chk("R4 frame", status_word, 16'hC000);
    ev_sw_req = 1'b1; ev_early_rx = 1'b1; ev_pause = 1'b1; tick();
    ev_sw_req = 1'b0; ev_early_rx = 1'b0; ev_pause = 1'b0;
    chk("R4 sw/early/pause", status_word, 16'hC700);
    bus_write(4'd0, 2'b11, 16'hFF00);
    chk("R2 clear all", status_word, 16'h0000);
    chk("R10 irq held one cycle", {15'b0, irq}, 16'h0001);
    tick();
    chk("R10 irq falls", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_mgmt();
    mgmt_irq_en = 1'b0;
    ev_mgmt_done = 1'b1; tick(); ev_mgmt_done = 1'b0;
    chk("R5 mgmt disabled", status_word, 16'h0000);
    tick();
    chk("R5 no irq when disabled", {15'b0, irq}, 16'h0000);
    mgmt_irq_en = 1'b1;
    ev_mgmt_done = 1'b1; tick(); ev_mgmt_done = 1'b0;
    chk("R5 mgmt enabled", status_word, 16'h0800);
    mgmt_irq_en = 1'b0;
    clear_all();
  endtask

  task automatic t_lanes();
    ev_cmd_done = 1'b1; ev_frame_rx = 1'b1; ev_pause = 1'b1; tick();
    ev_cmd_done = 1'b0; ev_frame_rx = 1'b0; ev_pause = 1'b0;
    bus_write(4'd0, 2'b10, 16'h4000);
    chk("R2 clear one bit", status_word, 16'h8100);
    bus_write(4'd0, 2'b01, 16'hFFFF);
    chk("R2 lane 1 disabled", status_word, 16'h8100);
    bus_write(4'd1, 2'b11, 16'hFFFF);
    chk("R11 other address write", status_word, 16'h8100);
    bus_write(4'd0, 2'b11, 16'h00FF);
    chk("R3 low byte ignored", status_word, 16'h8100);
    bus_addr = 4'd0; #1;
    chk("R11 read addr 0", bus_rdata, 16'h8100);
    bus_addr = 4'd3; #1;
    chk("R11 read other addr", bus_rdata, 16'h0000);
    bus_addr = 4'd0;
    clear_all();
  endtask

  task automatic t_cna_exit();
    cna_mode = 1'b0;
    cu_state = 2'b10; tick();
    chk("R6 idle to active no flag", status_word, 16'h0000);
    cu_state = 2'b01; tick();
    chk("R6 active to suspended", status_word, 16'h2000);
    clear_all();
    cu_state = 2'b10; tick(); cu_state = 2'b00; tick();
    chk("R6 active to idle", status_word, 16'h2000);
    clear_all();
    cu_state = 2'b01; tick();
    chk("R6 idle to suspended no flag", status_word, 16'h0000);
    cu_state = 2'b00; tick();
  endtask

  task automatic t_cna_idle();
    cna_mode = 1'b1;
    cu_state = 2'b10; tick();
    cu_state = 2'b01; tick();
    chk("R7 active to suspended no flag", status_word, 16'h0000);
    cu_state = 2'b00; tick();
    chk("R7 enter idle", status_word, 16'h2000);
    clear_all();
    tick();
    chk("R7 staying idle no flag", status_word, 16'h0000);
    cna_mode = 1'b0;
  endtask

  task automatic t_rnr();
    ru_state = 2'b10; tick();
    chk("R8 enter ready no flag", status_word, 16'h0000);
    ru_state = 2'b11; tick();
    chk("R8 ready to no-resources", status_word, 16'h1000);
    clear_all();
    ru_state = 2'b10; tick(); ru_state = 2'b01; tick();
    chk("R8 ready to suspended", status_word, 16'h1000);
    clear_all();
    ru_state = 2'b00; tick();
    chk("R8 suspended to idle no flag", status_word, 16'h0000);
  endtask

  task automatic t_collide();
    ev_frame_rx = 1'b1;
    bus_addr = 4'd0; bus_be = 2'b10; bus_wdata = 16'h4000; bus_wr = 1'b1;
    tick();
    ev_frame_rx = 1'b0; bus_wr = 1'b0; bus_be = 2'b00;
    chk("R9 set beats clear", status_word, 16'h4000);
    clear_all();
    chk("R2 cleared after collide", status_word, 16'h0000);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_pulses();
    t_mgmt();
    t_lanes();
    t_cna_exit();
    t_cna_idle();
    t_rnr();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule